// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches a group of external interrupt pins and merges them into a single interrupt request for the processor. Each pin is sampled through a two-flop synchronizer. Each line can be set up on its own to trigger on a rising edge, a falling edge, a high level or a low level. A detected trigger sets a sticky pending bit for that line. The pending bit stays set until software clears it. The request output is raised while any pending line is also enabled in the mask.

Software reaches the block over a plain register bus. A write takes effect at the clock edge on which `bus_we` is high. Read data is combinational from `bus_addr`. The bus has no valid/ready handshake, because a register access always completes in one cycle and cannot be back-pressured.

The mask is changed only through two write-one strobes: one sets mask bits and the other clears them. Configuration bits for lines that are not built read back as zero, so software can find the line count by writing all ones and reading the value back. A test mode replaces the synchronized pins with a value that software writes, which lets software drive the lines directly. A separate control bit enables the non-maskable path and appears on its own pin.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset, every readable register (mask 0x08, pending 0x0C, sense 0x14, edge direction 0x18, polarity 0x1C, test 0x20, non-maskable control 0x24) reads 0, `irq_o` is 0 and `nmi_en_o` is 0.
- R2: Writing to byte offset 0x00 sets the mask bit of every line whose data bit is 1. Zero data bits leave the mask unchanged. The mask reads back at 0x08.
- R3: Writing to byte offset 0x04 clears the mask bit of every line whose data bit is 1. Zero data bits leave the mask unchanged.
- R4: A line with sense bit 0 (edge) and edge-direction bit 0 sets its pending bit (bit i of 0x0C) on a falling edge and not on a rising edge. This is the reset configuration. The pending bit stays set until it is cleared.
- R5: A line with sense bit 0 and edge-direction bit 1 sets its pending bit on a rising edge and not on a falling edge.
- R6: A line with sense bit 1 (level) sets its pending bit on every cycle that its input equals its polarity bit (1 = active high, 0 = active low).
- R7: Writing to byte offset 0x10 clears the pending bit of every line whose data bit is 1, and zero bits leave it unchanged. A clear on a cycle where the line still triggers has no effect.
- R8: `irq_o` is 1 exactly when some line has both its pending bit and its mask bit set. A masked line still records its pending bit.
- R9: Sense, edge-direction, polarity and mask bits at positions LINES and above ignore writes and read 0. With LINES = 8, writing all ones reads back 0x000000FF.
- R10: Bit 31 of the test register (0x20) selects test mode. In test mode, bits LINES-1..0 of that register replace the synchronized pins, and changes on the pins have no effect. Bit 31 and bits LINES-1..0 read back, and the other bits read 0.
- R11: Bit 0 of the non-maskable control register (0x24) drives `nmi_en_o` and reads back. The other bits read 0.
- R12: A pin change in normal mode reaches the pending bit at the third rising clock edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | LINES | Asynchronous external interrupt pins |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Combined request: any line both pending and unmasked |
| nmi_en_o | output | 1 | Non-maskable path enable |

## Verification
A wrong pending bit shows up on a read of 0x0C in the very next cycle. If that line is unmasked, it also shows up on `irq_o` in the same cycle. A wrong mask or configuration bit only becomes visible once a trigger on that line occurs. For that reason the bench drives each trigger type on a dedicated line and reads the register back after every write. A synchronizer with the wrong depth moves the pending bit by one or more cycles. The bench catches this with an exact per-edge sample around a single pin change.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int unsigned DATA_W = 32;

  localparam logic [7:0] OFS_ARM     = 8'h00;
  localparam logic [7:0] OFS_DISARM  = 8'h04;
  localparam logic [7:0] OFS_MASK    = 8'h08;
  localparam logic [7:0] OFS_PEND    = 8'h0C;
  localparam logic [7:0] OFS_ACK     = 8'h10;
  localparam logic [7:0] OFS_SENSE   = 8'h14;
  localparam logic [7:0] OFS_EDGEDIR = 8'h18;
  localparam logic [7:0] OFS_POL     = 8'h1C;
  localparam logic [7:0] OFS_TEST    = 8'h20;
  localparam logic [7:0] OFS_NMI     = 8'h24;

  localparam int unsigned TEST_EN_BIT = 31;
  localparam int unsigned NMI_EN_BIT  = 0;

  typedef struct packed {
    logic arm;
    logic disarm;
    logic ack;
    logic sense;
    logic edgedir;
    logic pol;
    logic test;
    logic nmi;
  } wr_strobe_t;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int unsigned LINES  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o
);
  logic [LINES-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/extirq_detect.sv
module extirq_detect #(
  parameter int unsigned LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] src_i,
  input  logic [LINES-1:0] sense_i,
  input  logic [LINES-1:0] edgedir_i,
  input  logic [LINES-1:0] pol_i,
  input  logic [LINES-1:0] clr_i,
  output logic [LINES-1:0] pend_o
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic prev_q;
    logic pend_q;
    logic rise;
    logic fall;
    logic lvl_hit;
    logic hit;

    always_comb begin
      rise    = src_i[i] & ~prev_q;
      fall    = ~src_i[i] & prev_q;
      lvl_hit = (src_i[i] == pol_i[i]);
      if (sense_i[i]) hit = lvl_hit;
      else            hit = edgedir_i[i] ? rise : fall;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        prev_q <= src_i[i];
        pend_q <= (pend_q & ~clr_i[i]) | hit;
      end
    end

    assign pend_o[i] = pend_q;

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !clr_i[i]) |=> pend_q);

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !hit) |=> !pend_q);

    // R6
    level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_i[i] && (src_i[i] == pol_i[i])) |=> pend_q);
  end
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
  import extirq_pkg::*;
#(
  parameter int unsigned LINES  = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [LINES-1:0]  pend_i,
  output logic [LINES-1:0]  mask_o,
  output logic [LINES-1:0]  sense_o,
  output logic [LINES-1:0]  edgedir_o,
  output logic [LINES-1:0]  pol_o,
  output logic [LINES-1:0]  clr_o,
  output logic              test_en_o,
  output logic [LINES-1:0]  test_val_o,
  output logic              nmi_en_o,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int unsigned PAD_W = DATA_W - 1 - LINES;

  wr_strobe_t       wr;
  logic [LINES-1:0] wbits;
  logic [LINES-1:0] mask_q, sense_q, edgedir_q, pol_q, tval_q;
  logic             tmode_q, nmi_q;
  logic             unused_wbits;

  assign wbits        = bus_wdata[LINES-1:0];
  assign unused_wbits = ^bus_wdata[DATA_W-2:LINES];

  always_comb begin
    wr         = '0;
    wr.arm     = bus_we && (bus_addr == ADDR_W'(OFS_ARM));
    wr.disarm  = bus_we && (bus_addr == ADDR_W'(OFS_DISARM));
    wr.ack     = bus_we && (bus_addr == ADDR_W'(OFS_ACK));
    wr.sense   = bus_we && (bus_addr == ADDR_W'(OFS_SENSE));
    wr.edgedir = bus_we && (bus_addr == ADDR_W'(OFS_EDGEDIR));
    wr.pol     = bus_we && (bus_addr == ADDR_W'(OFS_POL));
    wr.test    = bus_we && (bus_addr == ADDR_W'(OFS_TEST));
    wr.nmi     = bus_we && (bus_addr == ADDR_W'(OFS_NMI));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      sense_q   <= '0;
      edgedir_q <= '0;
      pol_q     <= '0;
      tval_q    <= '0;
      tmode_q   <= 1'b0;
      nmi_q     <= 1'b0;
    end else begin
      if (wr.arm)     mask_q    <= mask_q | wbits;
      if (wr.disarm)  mask_q    <= mask_q & ~wbits;
      if (wr.sense)   sense_q   <= wbits;
      if (wr.edgedir) edgedir_q <= wbits;
      if (wr.pol)     pol_q     <= wbits;
      if (wr.test) begin
        tval_q  <= wbits;
        tmode_q <= bus_wdata[TEST_EN_BIT];
      end
      if (wr.nmi)     nmi_q     <= bus_wdata[NMI_EN_BIT];
    end
  end

  assign clr_o      = wr.ack ? wbits : '0;
  assign mask_o     = mask_q;
  assign sense_o    = sense_q;
  assign edgedir_o  = edgedir_q;
  assign pol_o      = pol_q;
  assign test_en_o  = tmode_q;
  assign test_val_o = tval_q;
  assign nmi_en_o   = nmi_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_MASK):    bus_rdata = DATA_W'(mask_q);
      ADDR_W'(OFS_PEND):    bus_rdata = DATA_W'(pend_i);
      ADDR_W'(OFS_SENSE):   bus_rdata = DATA_W'(sense_q);
      ADDR_W'(OFS_EDGEDIR): bus_rdata = DATA_W'(edgedir_q);
      ADDR_W'(OFS_POL):     bus_rdata = DATA_W'(pol_q);
      ADDR_W'(OFS_TEST):    bus_rdata = {tmode_q, {PAD_W{1'b0}}, tval_q};
      ADDR_W'(OFS_NMI):     bus_rdata = DATA_W'(nmi_q);
      default:              bus_rdata = '0;
    endcase
  end

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr.arm |=> ((mask_q & $past(wbits)) == $past(wbits)));

  // R3
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr.disarm |=> ((mask_q & $past(wbits)) == '0));

  // R11
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr.nmi |=> $stable(nmi_en_o));
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int unsigned LINES       = 8,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  pins_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              nmi_en_o
);
  logic [LINES-1:0] sync_q, src;
  logic [LINES-1:0] mask, sense, edgedir, pol, clr, tval, pend;
  logic             tmode;

  extirq_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pins_i),
    .q_o   (sync_q)
  );

  assign src = tmode ? tval : sync_q;

  extirq_detect #(.LINES(LINES)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src),
    .sense_i   (sense),
    .edgedir_i (edgedir),
    .pol_i     (pol),
    .clr_i     (clr),
    .pend_o    (pend)
  );

  extirq_regs #(.LINES(LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .pend_i     (pend),
    .mask_o     (mask),
    .sense_o    (sense),
    .edgedir_o  (edgedir),
    .pol_o      (pol),
    .clr_o      (clr),
    .test_en_o  (tmode),
    .test_val_o (tval),
    .nmi_en_o   (nmi_en_o),
    .bus_rdata  (bus_rdata)
  );

  assign irq_o = |(pend & mask);

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq_o);
endmodule

// File: tb/extirq_ctrl_bench.sv
module extirq_ctrl_bench;
  localparam int unsigned LINES = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins = 8'hFF;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, nmi_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q [$];
  int          kind_q [$];
  string       tag_q [$];
  logic [31:0] act, expv;
  int          kind;
  string       tag;

  always #5 clk = ~clk;

  extirq_ctrl #(.LINES(LINES)) u_extirq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins_i    (pins),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .nmi_en_o  (nmi_en_o)
  );

  // monitor: compares at the falling edge against queued expectations
  always @(negedge clk) begin
    while (kind_q.size() > 0) begin
      kind = kind_q.pop_front();
      expv = exp_q.pop_front();
      tag  = tag_q.pop_front();
      if (kind == 0)      act = bus_rdata;
      else if (kind == 1) act = {31'b0, irq_o};
      else                act = {31'b0, nmi_en_o};
      checks++;
      if (act !== expv) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    bus_addr = a;
    exp_q.push_back(e); kind_q.push_back(0); tag_q.push_back(t);
  endtask

  task automatic sig(input int k, input logic e, input string t);
    @(posedge clk); #1;
    exp_q.push_back({31'b0, e}); kind_q.push_back(k); tag_q.push_back(t);
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(posedge clk); #1;
    pins = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(8'h08, 32'h0, "R1 mask");
    rd(8'h0C, 32'h0, "R1 pending");
    rd(8'h14, 32'h0, "R1 sense");
    rd(8'h18, 32'h0, "R1 edgedir");
    rd(8'h1C, 32'h0, "R1 polarity");
    rd(8'h20, 32'h0, "R1 test");
    rd(8'h24, 32'h0, "R1 nmi ctl");
    sig(1, 1'b0, "R1 irq");
    sig(2, 1'b0, "R1 nmi_en");

    // R9 line count discovery
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, 32'h0000_00FF, "R9 sense");
    wr(8'h14, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, 32'h0000_00FF, "R9 edgedir");
    wr(8'h18, 32'h0);
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, 32'h0000_00FF, "R9 polarity");
    wr(8'h1C, 32'h0);
    rd(8'h0C, 32'h0, "R9 no trigger from config");

    // R2 / R3 mask set and clear
    wr(8'h00, 32'h05); rd(8'h08, 32'h05, "R2 set");
    wr(8'h00, 32'h02); rd(8'h08, 32'h07, "R2 zeros keep");
    wr(8'h00, 32'hFFFF_FF00); rd(8'h08, 32'h07, "R9 mask upper");
    wr(8'h04, 32'h04); rd(8'h08, 32'h03, "R3 clear");
    wr(8'h04, 32'hFF); rd(8'h08, 32'h00, "R3 clear all");

    // R4 falling edge default, sticky, masked
    set_pins(8'hFE); idle(4);
    rd(8'h0C, 32'h01, "R4 falling sets");
    sig(1, 1'b0, "R8 masked no irq");
    set_pins(8'hFF); idle(4);
    rd(8'h0C, 32'h01, "R4 rising ignored sticky");
    wr(8'h00, 32'h01);
    sig(1, 1'b1, "R8 unmasked irq");
    wr(8'h10, 32'h01);
    rd(8'h0C, 32'h00, "R7 clear");
    sig(1, 1'b0, "R8 irq drops");

    // R12 exact latency on line 1
    set_pins(8'hFD);
    rd(8'h0C, 32'h00, "R12 edge 1");
    rd(8'h0C, 32'h00, "R12 edge 2");
    rd(8'h0C, 32'h02, "R12 edge 3");
    sig(1, 1'b0, "R8 line1 masked");
    wr(8'h10, 32'h01); rd(8'h0C, 32'h02, "R7 zero bits keep");
    wr(8'h10, 32'h02); rd(8'h0C, 32'h00, "R7 clear line1");
    set_pins(8'hFF); idle(4);
    rd(8'h0C, 32'h00, "R4 line1 rise ignored");

    // R5 rising on line 2
    wr(8'h18, 32'h04);
    set_pins(8'hFB); idle(4);
    rd(8'h0C, 32'h00, "R5 falling ignored");
    set_pins(8'hFF); idle(4);
    rd(8'h0C, 32'h04, "R5 rising sets");
    wr(8'h10, 32'h04); rd(8'h0C, 32'h00, "R5 cleared");

    // R6 level on line 3
    wr(8'h14, 32'h08);
    rd(8'h0C, 32'h00, "R6 low-active idle");
    wr(8'h1C, 32'h08);
    rd(8'h0C, 32'h08, "R6 high-active sets");
    wr(8'h10, 32'h08); rd(8'h0C, 32'h08, "R7 clear while active");
    set_pins(8'hF7); idle(4);
    wr(8'h10, 32'h08); rd(8'h0C, 32'h00, "R6 inactive clears");
    wr(8'h1C, 32'h00);
    rd(8'h0C, 32'h08, "R6 low-active sets");
    set_pins(8'hFF); idle(4);
    wr(8'h10, 32'h08); rd(8'h0C, 32'h00, "R6 released");
    wr(8'h14, 32'h00);

    // R10 test mode
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, 32'h8000_00FF, "R10 readback");
    rd(8'h0C, 32'h00, "R10 enter quiet");
    wr(8'h20, 32'h8000_00FE);
    rd(8'h0C, 32'h01, "R10 soft falling");
    sig(1, 1'b1, "R10 irq");
    set_pins(8'hDF); idle(4);
    rd(8'h0C, 32'h01, "R10 pins ignored");
    set_pins(8'hFF); idle(4);
    wr(8'h20, 32'h8000_00FF);
    wr(8'h10, 32'h01);
    rd(8'h0C, 32'h00, "R10 cleared");
    wr(8'h20, 32'h0);
    rd(8'h20, 32'h0, "R10 exit");
    rd(8'h0C, 32'h00, "R10 exit quiet");

    // R11 non-maskable control
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, 32'h1, "R11 readback");
    sig(2, 1'b1, "R11 nmi_en high");
    wr(8'h24, 32'h0);
    sig(2, 1'b0, "R11 nmi_en low");

    idle(3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule